// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block models the digital face of a 12-bit sampling converter that talks over three wires: an active-low select, a serial clock driven by the host, and a data line. Pulling select low freezes a parallel test word, `sample_i`, as the value to convert and starts a busy period timed by a counter on the system clock. The serial clock plays no part in that period. The data line is driven low while the counter runs. It goes high when the counter expires, as an end-of-conversion marker. After that, each falling serial clock edge puts the next result bit on the line, most significant first. Once the word is exhausted, further edges put zeros out until select rises.

Select, serial clock and the active-low power-down input are brought into the system clock domain through synchronizer flops before any edge is detected. The data pin is modelled as a value and a separate drive enable; a low enable stands for the high-impedance state. Two sticky flags report protocol misuse to a testbench:
- serial clock activity during a conversion;
- a select high time that is too short.

Holding power-down low forces the pin to high impedance. After power-down is released, the block waits for a settling interval before a new conversion may start.

Top module: `sadc_emu`

## Requirements
- R1: After reset, with select high, `dout_en_o` is 0 and both `sclk_viol_o` and `cs_viol_o` are 0.
- R2: While select is high, `dout_en_o` is 0. A falling select in the idle state starts a conversion. Three system clock edges after the pin change, `dout_en_o` is 1 and `dout_o` is 0. A rising select releases the pin three edges after it changes.
- R3: `dout_o` stays 0 for exactly `CONV_CYC` system clock cycles of conversion and then goes to 1 (end-of-conversion).
- R4: The result is the value of `sample_i` at the start of conversion. Changes to `sample_i` after that have no effect on the bits shifted out.
- R5: After end-of-conversion, the k-th falling serial clock edge (k = 1..12) places bit 12-k of the captured word on `dout_o`. The first edge gives bit 11 (MSB) and the twelfth gives bit 0.
- R6: Falling serial clock edges after bit 0, while select stays low, drive `dout_o` to 0.
- R7: Falling serial clock edges during the conversion leave `dout_o` at 0 and do not disturb the later frame. They set `sclk_viol_o`, which stays 1 until reset.
- R8: Raising select during the conversion aborts it and releases the pin. After an abort, a falling select is refused (pin stays released) unless select was high for at least `ACQ_CYC` cycles.
- R9: Power-down low for three edges releases the pin and cancels any conversion. After release of power-down, a falling select within `WAKE_CYC` cycles is ignored. Once that interval has passed, a falling select starts a conversion.
- R10: A falling select in the idle state after a select high time of fewer than `CS_MIN_CYC` cycles sets `cs_viol_o`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low, asynchronous to clk_i |
| sclk_i | input | 1 | Host serial clock, idle low |
| shdn_ni | input | 1 | Power-down, active low |
| sample_i | input | DATA_W | Test value converted on each start |
| dout_o | output | 1 | Serial data value |
| dout_en_o | output | 1 | Data drive enable (0 = high impedance) |
| sclk_viol_o | output | 1 | Sticky: serial clock edge seen during conversion |
| cs_viol_o | output | 1 | Sticky: select high time below minimum |

## Verification
Every pin change reaches the outputs three system clock edges later: two synchronizer flops plus the edge-detect flop. The bench therefore drives pins at a falling clock edge and samples at the falling edge after the counted number of rising edges. End-of-conversion is checked at both sides of its boundary. `dout_o` must still be 0 after edge `CONV_CYC`+2 and must be 1 after edge `CONV_CYC`+3. Each data bit is sampled four edges after its serial clock fall, which sits well inside the next serial clock phase. Select high times for the abort and minimum-pulse cases are counted in whole cycles, so each case lands on a known side of its threshold.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAKE = 3'd1,
    ST_IDLE = 3'd2,
    ST_CONV = 3'd3,
    ST_READ = 3'd4
  } st_e;
endpackage

// File: rtl/sadc_sync.sv
`timescale 1ns/1ps
module sadc_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sadc_ctrl.sv
`timescale 1ns/1ps
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int CONV_CYC   = 24,
  parameter int WAKE_CYC   = 30,
  parameter int ACQ_CYC    = 16,
  parameter int CS_MIN_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sclk_s_i,
  input  logic shdn_s_i,
  output st_e  st_o,
  output logic load_o,
  output logic eoc_o,
  output logic shift_o,
  output logic sclk_viol_o,
  output logic cs_viol_o
);
  localparam int TMAX   = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int CNT_W  = $clog2(TMAX + 1);
  localparam int HMAX   = (ACQ_CYC > CS_MIN_CYC) ? ACQ_CYC : CS_MIN_CYC;
  localparam int HCNT_W = $clog2(HMAX + 1);

  st_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HCNT_W-1:0] hi_q;
  logic              cs_d_q, sclk_d_q, ab_q, ab_d;
  logic              cs_fall, cs_rise, sclk_fall, hold_off;

  assign cs_fall   = cs_d_q & ~cs_s_i;
  assign cs_rise   = ~cs_d_q & cs_s_i;
  assign sclk_fall = sclk_d_q & ~sclk_s_i;
  // refuse a start too soon after an aborted conversion
  assign hold_off  = ab_q && (hi_q < HCNT_W'(ACQ_CYC));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + 1'b1;
    ab_d    = ab_q;
    load_o  = 1'b0;
    eoc_o   = 1'b0;
    shift_o = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        cnt_d = '0;
        if (shdn_s_i) st_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (cnt_q == CNT_W'(WAKE_CYC - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (cs_fall && !hold_off) begin
          st_d   = ST_CONV;
          load_o = 1'b1;
          ab_d   = 1'b0;
        end
      end
      ST_CONV: begin
        if (cs_rise) begin
          st_d = ST_IDLE;
          ab_d = 1'b1;
        end else if (cnt_q == CNT_W'(CONV_CYC - 1)) begin
          st_d  = ST_READ;
          eoc_o = 1'b1;
        end
      end
      ST_READ: begin
        cnt_d = '0;
        if (cs_rise)        st_d = ST_IDLE;
        else if (sclk_fall) shift_o = 1'b1;
      end
      default: st_d = ST_OFF;
    endcase
    if (!shdn_s_i) begin
      st_d    = ST_OFF;
      ab_d    = 1'b0;
      load_o  = 1'b0;
      eoc_o   = 1'b0;
      shift_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_OFF;
      cnt_q       <= '0;
      ab_q        <= 1'b0;
      cs_d_q      <= 1'b1;
      sclk_d_q    <= 1'b0;
      hi_q        <= HCNT_W'(HMAX);
      sclk_viol_o <= 1'b0;
      cs_viol_o   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      ab_q     <= ab_d;
      cs_d_q   <= cs_s_i;
      sclk_d_q <= sclk_s_i;
      if (!cs_s_i)                       hi_q <= '0;
      else if (hi_q != HCNT_W'(HMAX))    hi_q <= hi_q + 1'b1;
      if (st_q == ST_CONV && sclk_fall)  sclk_viol_o <= 1'b1;
      if (st_q == ST_IDLE && cs_fall && hi_q < HCNT_W'(CS_MIN_CYC))
        cs_viol_o <= 1'b1;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/sadc_shreg.sv
`timescale 1ns/1ps
module sadc_shreg #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              eoc_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      dout_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= sample_i;
      dout_o <= 1'b0;
    end else if (eoc_i) begin
      dout_o <= 1'b1;
    end else if (shift_i) begin
      dout_o <= sh_q[DATA_W-1];
      sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sadc_emu.sv
`timescale 1ns/1ps
module sadc_emu
  import sadc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYC    = 425,
  parameter int WAKE_CYC    = 1000,
  parameter int ACQ_CYC     = 75,
  parameter int CS_MIN_CYC  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              shdn_ni,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic              sclk_viol_o,
  output logic              cs_viol_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] pins_s;
  logic             load, eoc, shift;
  st_e              st;

  sadc_sync #(
    .W       (NSYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b101)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({shdn_ni, sclk_i, cs_ni}),
    .q_o    (pins_s)
  );

  sadc_ctrl #(
    .CONV_CYC   (CONV_CYC),
    .WAKE_CYC   (WAKE_CYC),
    .ACQ_CYC    (ACQ_CYC),
    .CS_MIN_CYC (CS_MIN_CYC)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s_i      (pins_s[0]),
    .sclk_s_i    (pins_s[1]),
    .shdn_s_i    (pins_s[2]),
    .st_o        (st),
    .load_o      (load),
    .eoc_o       (eoc),
    .shift_o     (shift),
    .sclk_viol_o (sclk_viol_o),
    .cs_viol_o   (cs_viol_o)
  );

  sadc_shreg #(
    .DATA_W (DATA_W)
  ) u_shreg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .eoc_i    (eoc),
    .shift_i  (shift),
    .sample_i (sample_i),
    .dout_o   (dout_o)
  );

  assign dout_en_o = (st == ST_CONV) || (st == ST_READ);
endmodule

// File: rtl/sadc_emu_chk.sv
`timescale 1ns/1ps
module sadc_emu_chk
  import sadc_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic shdn_ni,
  input logic dout_o,
  input logic dout_en_o,
  input logic sclk_viol_o,
  input logic cs_viol_o,
  input st_e  st_i
);
  assert_hiz_cs_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !dout_en_o);

  assert_busy_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_CONV) |-> (dout_en_o && !dout_o));

  assert_rise_only_reading_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_en_o && $rose(dout_o)) |-> (st_i == ST_READ));

  assert_sclk_viol_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_viol_o |=> sclk_viol_o);

  assert_sclk_viol_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_viol_o) |-> ($past(st_i) == ST_CONV));

  assert_shdn_hiz_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_ni && !$past(shdn_ni) && !$past(shdn_ni, 2) && !$past(shdn_ni, 3)) |-> !dout_en_o);

  assert_cs_viol_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_viol_o |=> cs_viol_o);
endmodule

bind sadc_emu sadc_emu_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .shdn_ni     (shdn_ni),
  .dout_o      (dout_o),
  .dout_en_o   (dout_en_o),
  .sclk_viol_o (sclk_viol_o),
  .cs_viol_o   (cs_viol_o),
  .st_i        (st)
);

// File: tb/sim_sadc_emu.sv
`timescale 1ns/1ps
module sim_sadc_emu;
  localparam int DW    = 12;
  localparam int CONV  = 24;
  localparam int WAKE  = 30;
  localparam int ACQ   = 16;
  localparam int CSMIN = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, shdn_ni = 1'b1;
  logic [DW-1:0] sample = '0;
  logic dout, dout_en, sclk_viol, cs_viol;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sadc_emu #(
    .DATA_W (DW), .SYNC_STAGES (2), .CONV_CYC (CONV),
    .WAKE_CYC (WAKE), .ACQ_CYC (ACQ), .CS_MIN_CYC (CSMIN)
  ) u0 (
    .clk_i (clk), .rst_ni (rst_ni), .cs_ni (cs_ni), .sclk_i (sclk),
    .shdn_ni (shdn_ni), .sample_i (sample), .dout_o (dout),
    .dout_en_o (dout_en), .sclk_viol_o (sclk_viol), .cs_viol_o (cs_viol)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_bits(input logic [DW-1:0] v, input int extra);
    for (int i = 0; i < DW + extra; i++) begin
      sclk = 1'b1; tick(3);
      sclk = 1'b0; tick(4);
      if (i < DW) chk("R5 data bit", int'(dout), int'(v[DW-1-i]));
      else        chk("R6 trailing zero", int'(dout), 0);
    end
  endtask

  task automatic frame(input logic [DW-1:0] v, input int extra);
    sample = v;
    cs_ni = 1'b0; tick(4);
    chk("R2 drive enable", int'(dout_en), 1);
    chk("R2 busy low", int'(dout), 0);
    sample = ~v;  // R4: late change must not matter
    tick(CONV - 2);
    chk("R3 still busy", int'(dout), 0);
    tick(1);
    chk("R3 end of conversion", int'(dout), 1);
    read_bits(v, extra);
    cs_ni = 1'b1; tick(4);
    chk("R2 released", int'(dout_en), 0);
    tick(20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(WAKE + 20);
    chk("R1 reset hiz", int'(dout_en), 0);
    chk("R1 sclk flag clear", int'(sclk_viol), 0);
    chk("R1 cs flag clear", int'(cs_viol), 0);

    // sweep of result words and trailing-edge counts (R4 R5 R6)
    frame(12'h000, 1);
    frame(12'hFFF, 2);
    frame(12'h800, 0);
    frame(12'h001, 3);
    for (int k = 0; k < 16; k++)
      frame(DW'((k * 273) ^ (k * k * 37)), k % 4);

    // R7: serial clock during conversion
    sample = 12'hA5C;
    cs_ni = 1'b0; tick(6);
    sclk = 1'b1; tick(3);
    sclk = 1'b0; tick(4);
    chk("R7 busy unaffected", int'(dout), 0);
    chk("R7 enable", int'(dout_en), 1);
    chk("R7 flag set", int'(sclk_viol), 1);
    tick(CONV);
    chk("R7 eoc", int'(dout), 1);
    read_bits(12'hA5C, 1);
    cs_ni = 1'b1; tick(24);

    // R8: abort then early and late restarts
    sample = 12'h3C3;
    cs_ni = 1'b0; tick(8);
    cs_ni = 1'b1; tick(4);
    chk("R8 abort release", int'(dout_en), 0);
    tick(6);
    cs_ni = 1'b0; tick(6);
    chk("R8 early start refused", int'(dout_en), 0);
    chk("R10 no flag at 10 cycles", int'(cs_viol), 0);
    cs_ni = 1'b1; tick(20);
    cs_ni = 1'b0; tick(4);
    chk("R8 late start accepted", int'(dout_en), 1);
    tick(CONV);
    chk("R8 eoc after restart", int'(dout), 1);
    read_bits(12'h3C3, 0);
    cs_ni = 1'b1; tick(24);

    // R9: power-down and wake interval
    cs_ni = 1'b0; tick(CONV + 6);
    chk("R9 pre shutdown eoc", int'(dout), 1);
    shdn_ni = 1'b0; tick(4);
    chk("R9 shutdown hiz", int'(dout_en), 0);
    cs_ni = 1'b1; tick(10);
    shdn_ni = 1'b1; tick(5);
    cs_ni = 1'b0; tick(5);
    chk("R9 start during wake ignored", int'(dout_en), 0);
    cs_ni = 1'b1; tick(40);
    frame(12'h6B1, 1);

    // R10: short select high time
    chk("R10 flag still clear", int'(cs_viol), 0);
    cs_ni = 1'b0; tick(6);
    cs_ni = 1'b1; tick(2);
    cs_ni = 1'b0; tick(5);
    chk("R10 short pulse flagged", int'(cs_viol), 1);
    cs_ni = 1'b1; tick(30);
    chk("R10 flag sticky", int'(cs_viol), 1);
    chk("R7 flag sticky", int'(sclk_viol), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule